// File: doc/BRIEF.md
# Signal Power Monitor with Mode Select

This block gathers statistics on a sampled signal over a programmable window of N samples and reports one figure per window. It can report the average power of the signal, either as mean-square power or as its root (RMS magnitude). It can also report the largest sample magnitude seen in the window, or the number of samples whose magnitude is above a programmed threshold. A complex mode treats the two sample inputs as the I and Q parts of one signal, so the power of each sample is I² + Q².

A new sample arrives on every clock while the monitor is enabled. The window length N is a power of two, so the average is a right shift. At the last sample of a window the accumulators close and restart at once for the next window. Peak, count and mean-square results appear one clock later. The RMS result needs an iterative square root and appears a fixed number of cycles later. Each result is marked by a one-clock valid pulse.

Top module: `power_monitor`

## Requirements
- R1: After reset, `resultValid` is 0 and `resultWord` is 0.
- R2: `modeCode` selects the reported figure: 2'b00 power, 2'b01 peak, 2'b10 and 2'b11 threshold count. The mode in force at the last sample of a window decides that window's result.
- R3: In power mode with `rmsSel` = 1, the result is floor(sum of sample powers / N) over the window. The power of a sample is sampA² when `cplxEn` = 0. This result is valid on the first clock after the window's last sample.
- R4: With `cplxEn` = 1, the power of a sample is sampA² + sampB², up to 524288 for two full-scale negative inputs.
- R5: In power mode with `rmsSel` = 0, the result is the integer square root (floor) of the mean-square value. It is zero-extended to 20 bits and valid 10 clocks after the window's last sample.
- R6: In peak mode, the result is the largest |sampA| in the window, zero-extended. It can reach 512 for an input of -512 and is valid on the first clock after the last sample.
- R7: In threshold mode, the result counts the samples of the window with |sampA| strictly greater than `threshold`. The count saturates at 1023 and is valid on the first clock after the last sample.
- R8: N = 2^k, where k is `periodLog2` clamped to the range 4 to 11. Values below 4 give 16 samples and values above 11 give 2048 samples. The next window starts on the sample right after the last one.
- R9: `resultValid` is high for exactly one clock per window. While `monEn` is 0 no sample is taken, no result is raised, and the sample count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sampA | input | 10 | Signed sample, channel A (I in complex mode) |
| sampB | input | 10 | Signed sample, channel B (Q in complex mode) |
| monEn | input | 1 | Monitor enable |
| cplxEn | input | 1 | Complex I/Q power mode |
| rmsSel | input | 1 | 0 = RMS result, 1 = mean-square result |
| modeCode | input | 2 | 00 power, 01 peak, 1x threshold count |
| periodLog2 | input | 4 | log2 of window length, clamped to 4..11 |
| threshold | input | 10 | Unsigned magnitude threshold |
| resultWord | output | 20 | Result of the last completed window |
| resultValid | output | 1 | One-clock pulse when resultWord is new |

## Verification
The assertions check on every cycle that a valid pulse never lasts two clocks and that nothing is raised while the monitor is disabled. They also check that peak and count results appear on the clock after a window closes and stay inside their ranges, and that the RMS result never appears on that clock while the mean-square result always does. Only the bench scenarios show the numbers themselves. These cover the mean of squares and its root, the I/Q sum, the largest magnitude, the strict threshold compare and its saturation, and the clamping of the window length, all checked against values the bench derives from the samples it drove.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int SHIFT_W = 4;

  typedef struct packed {
    logic               clear;    // drop window state
    logic               accum;    // fold current sample into window
    logic               close;    // last sample of window
    logic               emit;     // closing result goes straight out
    logic               rootStep; // one square-root iteration
    logic               rootLast; // final square-root iteration
    logic [SHIFT_W-1:0] rootBit;  // bit under test in the root
    logic [SHIFT_W-1:0] shift;    // effective log2 of window length
  } pm_ctl_t;
endpackage

// File: rtl/pm_control.sv
module pm_control
  import pm_pkg::*;
#(
  parameter int MIN_LOG = 4,
  parameter int MAX_LOG = 11,
  parameter int ROOT_W  = 10,
  parameter int LOG_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             monEn,
  input  logic             rmsSel,
  input  logic [1:0]       modeCode,
  input  logic [LOG_W-1:0] periodLog2,
  output pm_ctl_t          ctl
);
  localparam int CNT_W = MAX_LOG;

  logic [CNT_W-1:0]   sampleCnt;
  logic [CNT_W-1:0]   lastIdx;
  logic [SHIFT_W-1:0] kEff;
  logic               rootBusy;
  logic [SHIFT_W-1:0] bitIdx;
  logic               closeNow;
  logic               directOut;

  always_comb begin
    if (periodLog2 < LOG_W'(MIN_LOG))      kEff = SHIFT_W'(MIN_LOG);
    else if (periodLog2 > LOG_W'(MAX_LOG)) kEff = SHIFT_W'(MAX_LOG);
    else                                   kEff = SHIFT_W'(periodLog2);
    lastIdx   = {CNT_W{1'b1}} >> (SHIFT_W'(MAX_LOG) - kEff);
    closeNow  = monEn && (sampleCnt >= lastIdx);
    directOut = !((modeCode == 2'b00) && !rmsSel);
  end

  always_ff @(posedge clk) begin
    if (rst || !monEn) begin
      sampleCnt <= '0;
      rootBusy  <= 1'b0;
      bitIdx    <= '0;
    end else begin
      sampleCnt <= closeNow ? '0 : sampleCnt + 1'b1;
      if (closeNow && !directOut) begin
        rootBusy <= 1'b1;
        bitIdx   <= SHIFT_W'(ROOT_W - 1);
      end else if (rootBusy) begin
        rootBusy <= (bitIdx != '0);
        bitIdx   <= bitIdx - 1'b1;
      end
    end
  end

  always_comb begin
    ctl.clear    = !monEn;
    ctl.accum    = monEn && !closeNow;
    ctl.close    = closeNow;
    ctl.emit     = directOut;
    ctl.rootStep = monEn && rootBusy;
    ctl.rootLast = monEn && rootBusy && (bitIdx == '0);
    ctl.rootBit  = bitIdx;
    ctl.shift    = kEff;
  end
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int MAX_LOG  = 11,
  parameter int CNT_W    = 10,
  parameter int RES_W    = 20
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sampA,
  input  logic signed [SAMPLE_W-1:0] sampB,
  input  logic                       cplxEn,
  input  logic [1:0]                 modeCode,
  input  logic [SAMPLE_W-1:0]        threshold,
  input  pm_ctl_t                    ctl,
  output logic [RES_W-1:0]           resultWord,
  output logic                       resultValid
);
  localparam int POW_W  = 2 * SAMPLE_W;
  localparam int ACC_W  = POW_W + MAX_LOG;
  localparam int ROOT_W = SAMPLE_W;

  logic [ACC_W-1:0]    powAcc, powAccNext;
  logic [SAMPLE_W-1:0] peakReg, peakNext;
  logic [CNT_W-1:0]    hitCnt, hitCntNext;
  logic [POW_W-1:0]    radicand;
  logic [ROOT_W-1:0]   rootReg, rootNext, trial;
  logic [2*ROOT_W-1:0] trialSq;
  logic [SAMPLE_W-1:0] magA, magB;
  logic [POW_W-1:0]    powA, powB, powSum, meanVal;
  logic [RES_W-1:0]    directRes;

  always_comb begin
    magA   = sampA[SAMPLE_W-1] ? SAMPLE_W'(-sampA) : SAMPLE_W'(sampA);
    magB   = sampB[SAMPLE_W-1] ? SAMPLE_W'(-sampB) : SAMPLE_W'(sampB);
    powA   = POW_W'(magA) * POW_W'(magA);
    powB   = POW_W'(magB) * POW_W'(magB);
    powSum = cplxEn ? powA + powB : powA;

    powAccNext = powAcc + ACC_W'(powSum);
    peakNext   = (magA > peakReg) ? magA : peakReg;
    hitCntNext = hitCnt;
    if ((magA > threshold) && (hitCnt != {CNT_W{1'b1}}))
      hitCntNext = hitCnt + 1'b1;
    meanVal = POW_W'(powAccNext >> ctl.shift);

    case (modeCode)
      2'b00:   directRes = RES_W'(meanVal);
      2'b01:   directRes = RES_W'(peakNext);
      default: directRes = RES_W'(hitCntNext);
    endcase

    trial    = rootReg | (ROOT_W'(1) << ctl.rootBit);
    trialSq  = (2*ROOT_W)'(trial) * (2*ROOT_W)'(trial);
    rootNext = ((2*ROOT_W)'(trialSq) <= (2*ROOT_W)'(radicand)) ? trial : rootReg;
  end

  // window accumulators
  always_ff @(posedge clk) begin
    if (rst || ctl.clear || ctl.close) begin
      powAcc  <= '0;
      peakReg <= '0;
      hitCnt  <= '0;
    end else if (ctl.accum) begin
      powAcc  <= powAccNext;
      peakReg <= peakNext;
      hitCnt  <= hitCntNext;
    end
  end

  // square root and result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      radicand    <= '0;
      rootReg     <= '0;
      resultWord  <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (ctl.close && ctl.emit) begin
        resultWord  <= directRes;
        resultValid <= 1'b1;
      end else if (ctl.close) begin
        radicand <= meanVal;
        rootReg  <= '0;
      end else if (ctl.rootStep) begin
        rootReg <= rootNext;
        if (ctl.rootLast) begin
          resultWord  <= RES_W'(rootNext);
          resultValid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/power_monitor.sv
module power_monitor
  import pm_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int MIN_LOG  = 4,
  parameter int MAX_LOG  = 11,
  parameter int CNT_W    = 10,
  parameter int LOG_W    = 4,
  parameter int RES_W    = 2 * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sampA,
  input  logic [SAMPLE_W-1:0] sampB,
  input  logic                monEn,
  input  logic                cplxEn,
  input  logic                rmsSel,
  input  logic [1:0]          modeCode,
  input  logic [LOG_W-1:0]    periodLog2,
  input  logic [SAMPLE_W-1:0] threshold,
  output logic [RES_W-1:0]    resultWord,
  output logic                resultValid
);
  pm_ctl_t ctlStb;

  pm_control #(
    .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .ROOT_W(SAMPLE_W), .LOG_W(LOG_W)
  ) u_control (
    .clk(clk), .rst(rst), .monEn(monEn), .rmsSel(rmsSel),
    .modeCode(modeCode), .periodLog2(periodLog2), .ctl(ctlStb)
  );

  pm_datapath #(
    .SAMPLE_W(SAMPLE_W), .MAX_LOG(MAX_LOG), .CNT_W(CNT_W), .RES_W(RES_W)
  ) u_datapath (
    .clk(clk), .rst(rst), .sampA(sampA), .sampB(sampB), .cplxEn(cplxEn),
    .modeCode(modeCode), .threshold(threshold), .ctl(ctlStb),
    .resultWord(resultWord), .resultValid(resultValid)
  );
endmodule

// File: rtl/pm_checker.sv
module pm_checker
  import pm_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        monEn,
  input logic        rmsSel,
  input logic [1:0]  modeCode,
  input pm_ctl_t     ctl,
  input logic [19:0] resultWord,
  input logic        resultValid
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    resultValid |=> !resultValid);

  a_r9_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    !monEn |=> !resultValid);

  a_r6_peak_ready: assert property (@(posedge clk) disable iff (rst)
    (ctl.close && modeCode == 2'b01) |=> (resultValid && resultWord <= 20'd512));

  a_r7_count_ready: assert property (@(posedge clk) disable iff (rst)
    (ctl.close && modeCode[1]) |=> (resultValid && resultWord <= 20'd1023));

  a_r3_ms_ready: assert property (@(posedge clk) disable iff (rst)
    (ctl.close && modeCode == 2'b00 && rmsSel) |=> resultValid);

  a_r5_rms_deferred: assert property (@(posedge clk) disable iff (rst)
    (ctl.close && modeCode == 2'b00 && !rmsSel) |=> !resultValid);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!resultValid && resultWord == 20'd0));
endmodule

bind power_monitor pm_checker u_pm_checker (
  .clk(clk), .rst(rst), .monEn(monEn), .rmsSel(rmsSel), .modeCode(modeCode),
  .ctl(ctlStb), .resultWord(resultWord), .resultValid(resultValid)
);

// File: tb/power_monitor_bench.sv
module power_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] sampA = '0, sampB = '0;
  logic       monEn = 1'b0, cplxEn = 1'b0, rmsSel = 1'b1;
  logic [1:0] modeCode = 2'b00;
  logic [3:0] periodLog2 = 4'd4;
  logic [9:0] threshold = '0;
  logic [19:0] resultWord;
  logic        resultValid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  power_monitor u_power_monitor (
    .clk(clk), .rst(rst), .sampA(sampA), .sampB(sampB), .monEn(monEn),
    .cplxEn(cplxEn), .rmsSel(rmsSel), .modeCode(modeCode),
    .periodLog2(periodLog2), .threshold(threshold),
    .resultWord(resultWord), .resultValid(resultValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int absVal(input logic [9:0] s);
    return s[9] ? 1024 - int'(s) : int'(s);
  endfunction

  function automatic longint floorRoot(input longint x);
    longint r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  function automatic int clampLog(input int k);
    return (k < 4) ? 4 : ((k > 11) ? 11 : k);
  endfunction

  function automatic logic [9:0] makeSample(input int pattern, input int idx, input int n);
    case (pattern)
      1: return 10'h200;                                  // -512 full scale
      2: return (idx == n - 37) ? 10'h1F4 : 10'($urandom % 64) - 10'd32;
      default: return 10'($urandom);
    endcase
  endfunction

  // one full window; pattern picks the sample stream
  task automatic runWindow(input string req, input logic [1:0] mode, input logic rms,
                           input logic cplx, input int k, input logic [9:0] thr,
                           input int pattern);
    int n = 1 << clampLog(k);
    longint powSum = 0;
    int peak = 0, hits = 0, seenAt = -1, pulses = 0;
    longint expVal;
    longint gotVal = 0;
    @(negedge clk);
    monEn = 1'b0;
    @(negedge clk);
    modeCode = mode; rmsSel = rms; cplxEn = cplx;
    periodLog2 = 4'(k); threshold = thr; monEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [9:0] a = makeSample(pattern, i, n);
      logic [9:0] b = makeSample(pattern, i + 1, n);
      sampA = a; sampB = b;
      powSum += longint'(absVal(a) * absVal(a));
      if (cplx) powSum += longint'(absVal(b) * absVal(b));
      if (absVal(a) > peak) peak = absVal(a);
      if (absVal(a) > int'(thr)) hits++;
      @(negedge clk);
      if (i < n - 1 && resultValid) pulses++;
    end
    sampA = '0; sampB = '0;
    for (int w = 0; w < 15; w++) begin
      if (resultValid) begin
        pulses++;
        if (seenAt < 0) begin seenAt = w; gotVal = longint'(resultWord); end
      end
      @(negedge clk);
    end
    monEn = 1'b0;
    if (mode == 2'b00) expVal = rms ? (powSum >> clampLog(k)) : floorRoot(powSum >> clampLog(k));
    else if (mode == 2'b01) expVal = peak;
    else expVal = (hits > 1023) ? 1023 : hits;
    check({req, " value"}, gotVal, expVal);
    check({req, " latency"}, seenAt, (mode == 2'b00 && !rms) ? 10 : 0);
    check("R9 one pulse per window", pulses, 1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset valid", resultValid, 0);
    check("R1 reset word", resultWord, 0);
    rst = 1'b0;

    runWindow("R3 mean-square real", 2'b00, 1'b1, 1'b0, 4, 10'd0, 0);
    runWindow("R5 rms real", 2'b00, 1'b0, 1'b0, 5, 10'd0, 0);
    runWindow("R4 mean-square complex", 2'b00, 1'b1, 1'b1, 4, 10'd0, 0);
    runWindow("R4 complex full scale ms", 2'b00, 1'b1, 1'b1, 4, 10'd0, 1);
    runWindow("R5 complex full scale rms", 2'b00, 1'b0, 1'b1, 6, 10'd0, 1);
    runWindow("R6 peak random", 2'b01, 1'b1, 1'b0, 5, 10'd0, 0);
    runWindow("R6 peak at -512", 2'b01, 1'b0, 1'b0, 4, 10'd0, 1);
    runWindow("R8 clamp high peak", 2'b01, 1'b1, 1'b0, 15, 10'd0, 2);
    runWindow("R7 threshold random", 2'b10, 1'b1, 1'b0, 6, 10'd300, 0);
    runWindow("R2 code 11 is threshold", 2'b11, 1'b0, 1'b0, 4, 10'd100, 0);
    runWindow("R7 strict compare", 2'b10, 1'b1, 1'b0, 4, 10'd512, 1);
    runWindow("R7 saturate", 2'b10, 1'b1, 1'b0, 11, 10'd0, 1);
    runWindow("R8 clamp low count", 2'b10, 1'b1, 1'b0, 2, 10'd0, 1);

    for (int r = 0; r < 16; r++) begin
      logic [1:0] m = 2'($urandom);
      runWindow("R2 random mix", m, 1'($urandom), 1'($urandom),
                4 + int'($urandom % 3), 10'($urandom % 512), 0);
    end

    // R9: disabled monitor raises nothing
    begin
      int quietPulses = 0;
      @(negedge clk);
      monEn = 1'b0; modeCode = 2'b01;
      for (int i = 0; i < 40; i++) begin
        sampA = 10'($urandom);
        @(negedge clk);
        if (resultValid) quietPulses++;
      end
      check("R9 disabled no result", quietPulses, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule